// File: doc/BRIEF.md
# Registered Inverting Bus Transceiver

This block links two parallel buses, A and B, in either direction. Each direction has its own holding register, and each register has its own capture clock. The A-to-B register samples bus A and the B-to-A register samples bus B. When outputs are enabled, a direction input picks which bus is driven. For the driven bus, a per-direction source select chooses between live data from the opposite bus and the held register contents. Every driven value is the bitwise complement of its source.

The tri-state pads are modelled as three vectors per bus: an input vector, an output vector and a per-bus output enable. The pad ring combines them into real bidirectional pins. Both registers keep capturing while outputs are off. This lets the block act as a two-way sample store in isolation and replay the stored words later.

Top module: `xcvr_reg_inv`

## Requirements
- R1: On a rising edge of `clk_ab`, the A-to-B register loads the raw (non-inverted) value of `a_in`. On a rising edge of `clk_ba`, the B-to-A register loads the raw value of `b_in`. An edge on one clock never alters the other register.
- R2: While `oe_n` is 1 (isolation), both `a_oe` and `b_oe` are 0.
- R3: While `oe_n` is 0, `dir`=1 gives `b_oe`=1 and `a_oe`=0, and `dir`=0 gives `a_oe`=1 and `b_oe`=0. The two enables are never 1 together.
- R4: Live source (select value 0): while B is driven with `sel_ab`=0, `b_out` equals `~a_in`. While A is driven with `sel_ba`=0, `a_out` equals `~b_in`. Both follow the inputs without a clock.
- R5: Stored source (select value 1): while B is driven with `sel_ab`=1, `b_out` equals the complement of the A-to-B register. While A is driven with `sel_ba`=1, `a_out` equals the complement of the B-to-A register.
- R6: Capture does not depend on `oe_n`, `dir` or the selects. A register loaded in isolation or in either drive direction holds that value for later stored output.
- R7: `rst_n`=0 clears both registers to 0 at once, without a clock edge. Stored output afterwards reads all ones.
- R8: A bus whose output enable is 0 has its output vector held at all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 1 drives B from the A side, 0 drives A from the B side |
| sel_ab | input | 1 | Source for bus B: 0 live `a_in`, 1 stored A-to-B word |
| sel_ba | input | 1 | Source for bus A: 0 live `b_in`, 1 stored B-to-A word |
| a_in | input | W | Value sensed on bus A |
| b_in | input | W | Value sensed on bus B |
| a_out | output | W | Value presented to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | W | Value presented to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench builds the block with `W`=4 and keeps the default `INVERT`=1. At four bits, every stored A-side word from 0 to 15 can be paired with a B-side word, and each pair is read back under all sixteen settings of `oe_n`, `dir`, `sel_ab` and `sel_ba`. These sweeps cover every enable and select combination against fresh live values. They also show that each clock disturbs only its own register, and that words captured in isolation replay intact.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Which side of the link is being driven when outputs are on
   typedef enum logic {
      DRV_A_SIDE = 1'b0,
      DRV_B_SIDE = 1'b1
   } drive_side_e;

   // Source of a driven word
   typedef enum logic {
      SRC_LIVE = 1'b0,
      SRC_HELD = 1'b1
   } src_sel_e;

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
   import xcvr_pkg::*;
(
   input  logic oe_n,
   input  logic dir,
   output logic a_oe,
   output logic b_oe
);

   drive_side_e side;

   always_comb begin
      side = drive_side_e'(dir);
      a_oe = !oe_n && (side == DRV_A_SIDE);
      b_oe = !oe_n && (side == DRV_B_SIDE);
   end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int W      = 8,
   parameter bit INVERT = 1'b1
) (
   input  logic         sel,
   input  logic         en,
   input  logic [W-1:0] live,
   input  logic [W-1:0] held,
   output logic [W-1:0] out
);

   logic [W-1:0] pick;
   logic [W-1:0] shaped;

   always_comb begin
      pick = (src_sel_e'(sel) == SRC_HELD) ? held : live;
   end

   generate
      if (INVERT) begin : g_inv
         assign shaped = ~pick;
      end else begin : g_pass
         assign shaped = pick;
      end
   endgenerate

   assign out = en ? shaped : '0;

endmodule

// File: rtl/xcvr_reg_inv.sv
module xcvr_reg_inv #(
   parameter int W      = 8,
   parameter bit INVERT = 1'b1
) (
   input  logic         clk_ab,
   input  logic         clk_ba,
   input  logic         rst_n,
   input  logic         oe_n,
   input  logic         dir,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   output logic [W-1:0] b_out,
   output logic         b_oe
);

   generate
      if (W < 1) begin : g_bad_width
         $error("xcvr_reg_inv: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] q_ab;
   logic [W-1:0] q_ba;

   xcvr_store #(.W(W)) u_store_ab (
      .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(q_ab)
   );

   xcvr_store #(.W(W)) u_store_ba (
      .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(q_ba)
   );

   xcvr_drive_ctl u_ctl (
      .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe)
   );

   xcvr_lane #(.W(W), .INVERT(INVERT)) u_lane_b (
      .sel(sel_ab), .en(b_oe), .live(a_in), .held(q_ab), .out(b_out)
   );

   xcvr_lane #(.W(W), .INVERT(INVERT)) u_lane_a (
      .sel(sel_ba), .en(a_oe), .live(b_in), .held(q_ba), .out(a_out)
   );

endmodule

// File: rtl/xcvr_reg_inv_chk.sv
module xcvr_reg_inv_chk #(
   parameter int W      = 8,
   parameter bit INVERT = 1'b1
) (
   input logic         clk_ab,
   input logic         clk_ba,
   input logic         rst_n,
   input logic         oe_n,
   input logic         dir,
   input logic         sel_ab,
   input logic         sel_ba,
   input logic [W-1:0] a_in,
   input logic [W-1:0] b_in,
   input logic [W-1:0] a_out,
   input logic         a_oe,
   input logic [W-1:0] b_out,
   input logic         b_oe,
   input logic [W-1:0] q_ab,
   input logic [W-1:0] q_ba
);

   logic [W-1:0] fx_live_b;
   logic [W-1:0] fx_held_b;
   logic [W-1:0] fx_live_a;
   logic [W-1:0] fx_held_a;
   assign fx_live_b = INVERT ? ~a_in : a_in;
   assign fx_held_b = INVERT ? ~q_ab : q_ab;
   assign fx_live_a = INVERT ? ~b_in : b_in;
   assign fx_held_a = INVERT ? ~q_ba : q_ba;

   // R1
   ab_capture_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
      1'b1 |=> (q_ab == $past(a_in)));

   // R1
   ba_capture_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
      1'b1 |=> (q_ba == $past(b_in)));

   // R2
   isolation_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
      oe_n |-> (!a_oe && !b_oe));

   // R3
   oe_mutex_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
      $countones({a_oe, b_oe}) == (oe_n ? 0 : 1));

   // R4
   live_b_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (b_oe && !sel_ab) |-> (b_out == fx_live_b));

   // R4
   live_a_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (a_oe && !sel_ba) |-> (a_out == fx_live_a));

   // R5
   held_b_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (b_oe && sel_ab) |-> (b_out == fx_held_b));

   // R5
   held_a_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (a_oe && sel_ba) |-> (a_out == fx_held_a));

   // R8
   quiet_out_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
      ((!a_oe) |-> (a_out == '0)) and ((!b_oe) |-> (b_out == '0)));

endmodule

bind xcvr_reg_inv xcvr_reg_inv_chk #(.W(W), .INVERT(INVERT)) u_chk (
   .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n),
   .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
   .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
   .q_ab(q_ab), .q_ba(q_ba)
);

// File: tb/xcvr_reg_inv_tb.sv
module xcvr_reg_inv_tb;

   localparam int W = 4;
   localparam int N = 1 << W;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
   logic         oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   xcvr_reg_inv #(.W(W)) u_dut (
      .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n),
      .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic check(string req, logic [W+1:0] got, logic [W+1:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic pulse_ab();
      #2 clk_ab = 1'b1; #2 clk_ab = 1'b0; #1;
   endtask

   task automatic pulse_ba();
      #2 clk_ba = 1'b1; #2 clk_ba = 1'b0; #1;
   endtask

   // Model: drive all sixteen control combinations against stored words ra/rb
   task automatic sweep(logic [W-1:0] ra, logic [W-1:0] rb,
                        logic [W-1:0] la, logic [W-1:0] lb);
      a_in = la; b_in = lb;
      for (int c = 0; c < 16; c++) begin
         logic eb, ea;
         logic [W-1:0] xb, xa;
         {oe_n, dir, sel_ab, sel_ba} = 4'(c);
         #1;
         eb = !oe_n && dir;
         ea = !oe_n && !dir;
         xb = eb ? (sel_ab ? ~ra : ~la) : '0;
         xa = ea ? (sel_ba ? ~rb : ~lb) : '0;
         // R2 R3 enables
         check(oe_n ? "R2 isolation" : "R3 direction",
               {{W{1'b0}}, a_oe, b_oe}, {{W{1'b0}}, ea, eb});
         // R4 R5 R8 bus B word
         check(!eb ? "R8 B quiet" : (sel_ab ? "R5 B stored" : "R4 B live"),
               {2'b00, b_out}, {2'b00, xb});
         // R4 R5 R8 bus A word
         check(!ea ? "R8 A quiet" : (sel_ba ? "R5 A stored" : "R4 A live"),
               {2'b00, a_out}, {2'b00, xa});
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] rb;
      #3;
      // R7 reset: stored words read as all ones when driven
      oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
      check("R7 reset B", {2'b00, b_out}, {2'b00, {W{1'b1}}});
      dir = 1'b0; sel_ba = 1'b1; #1;
      check("R7 reset A", {2'b00, a_out}, {2'b00, {W{1'b1}}});
      rst_n = 1'b1; #5;

      for (int ra = 0; ra < N; ra++) begin
         rb = W'((ra * 5 + 3) % N);
         // R6: load both registers in isolation
         oe_n = 1'b1;
         a_in = W'(ra); pulse_ab();
         b_in = rb;     pulse_ba();
         // R1 and R6: replay with unrelated live values
         sweep(W'(ra), rb, W'((ra + 7) % N), W'((ra * 3 + 1) % N));
      end

      // R1: clk_ab leaves the B-to-A word alone; R6 capture while B driven
      oe_n = 1'b1; b_in = 4'h9; pulse_ba();
      oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
      a_in = 4'h6; b_in = 4'h0; pulse_ab();
      check("R1 B after clk_ab", {2'b00, b_out}, {2'b00, 4'h9});
      dir = 1'b0; #1;
      check("R1 A untouched by clk_ab", {2'b00, a_out}, {2'b00, 4'h6});
      // R6 capture into B-to-A while A is driven
      b_in = 4'hC; pulse_ba();
      check("R6 capture while A driven", {2'b00, a_out}, {2'b00, 4'h3});
      dir = 1'b1; #1;
      check("R1 B untouched by clk_ba", {2'b00, b_out}, {2'b00, 4'h9});

      // R7: asynchronous clear mid-run, no clock edge
      #2 rst_n = 1'b0; #1;
      check("R7 async clear B", {2'b00, b_out}, {2'b00, 4'hF});
      dir = 1'b0; #1;
      check("R7 async clear A", {2'b00, a_out}, {2'b00, 4'hF});
      rst_n = 1'b1; #5;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule